// File: doc/BRIEF.md
# Mixed-Clear Interrupt Status Controller

This block holds a 32-bit interrupt status word and a 32-bit enable word that a host reaches over a simple strobed register bus. Peripherals report conditions either as one-cycle event pulses or as levels. Each status position behaves in one of three ways:
- **Sticky event bits** latch a pulse until the host reads the status word or writes a one to that bit.
- **Level mirrors** follow a source that is cleared at its origin.
- **Fixed bits** are either reserved or computed.

A single interrupt line rises whenever a set status bit meets a set enable bit while the global bus-interrupt enable is on. Two further status bits are special. A summary bit collects a fixed group of event positions. A software interrupt bit is raised by a host write to a control word.

Reads are registered. The read data reflects the status as it stood on the strobe cycle. Any clearing takes effect from the cycle after the strobe. An event that arrives on the same cycle as a clear wins, so no event is lost. Timer-based second-level masking and the peripherals themselves are outside the block.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, or after a reset applied mid-run, the status, enable and control words read as zero and `irq_o` is low.
- R2: `irq_o` is high exactly when some bit of the status word (as read) ANDed with the enable word is one and the global enable (control bit 1) is one. It follows a register change in the same cycle that the change becomes visible.
- R3: A read strobe at byte address 0x80 registers the status value from before clearing into `rdata_o`. The sticky event bits (19:0, 24:21, 27) are zero from the next cycle on.
- R4: A write to 0x80 clears each sticky event bit whose data bit is one and leaves bits written with zero unchanged.
- R5: Bits 31:28 follow `gpio_i[3:0]` and bit 20 follows `bus_int_i`, each one cycle after the input. Reads and writes of 0x80 have no effect on them.
- R6: Bit 25 reads as the OR of status bits 24:16 and 7:1. It is never cleared by a write, and bits 0 and 15:8 do not contribute to it.
- R7: Bit 26 always reads zero.
- R8: Writing a one to control bit 0 (address 0x88) sets status bit 23. Control bit 0 itself always reads zero.
- R9: A one-cycle pulse on `evt_i[n]` sets bit n (for n in 19:0). `txq_low_i` sets bit 21, `rxq_low_i` sets bit 22, `timer_zero_i` sets bit 24 and `stat_wrap_i` sets bit 27. Each bit stays set until cleared.
- R10: A pulse on the same cycle as a read-clear or a write-one-clear of that bit leaves the bit set.
- R11: The enable word at 0x84 is fully read/write. Control bit 1 at 0x88 is the read/write global enable.
- R12: Reads of any other address return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, held between reads |
| evt_i | input | 20 | Event pulses for status bits 19:0 |
| txq_low_i | input | 1 | Transmit completion queue low pulse |
| rxq_low_i | input | 1 | Receive completion queue low pulse |
| timer_zero_i | input | 1 | General down-counter reached zero pulse |
| stat_wrap_i | input | 1 | Statistics counter wrap pulse |
| bus_int_i | input | 1 | Bus-status interrupt level |
| gpio_i | input | 4 | GPIO interrupt levels |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that event inputs are single-cycle pulses sampled at the rising edge, and that level inputs are synchronous to `clk_i`. They also assume that a bus strobe lasts exactly one cycle. The bench drives every input at the falling edge and holds each pulse and strobe for a single cycle. It samples `rdata_o` and `irq_o` at the following falling edge, so each check sees the value registered on the strobe edge. Collision cases present a pulse and a clearing strobe on the same edge, which is the one overlap the properties single out.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned EVT_W = 20;
  localparam int unsigned GPIO_W = 4;

  localparam int unsigned B_BUS_INT  = 20;
  localparam int unsigned B_TXQ      = 21;
  localparam int unsigned B_RXQ      = 22;
  localparam int unsigned B_SOFT     = 23;
  localparam int unsigned B_TIMER    = 24;
  localparam int unsigned B_SUMMARY  = 25;
  localparam int unsigned B_RSVD     = 26;
  localparam int unsigned B_WRAP     = 27;
  localparam int unsigned B_GPIO_LO  = 28;

  typedef enum logic [1:0] {K_EVENT, K_LEVEL, K_FIXED} bit_kind_e;

  function automatic bit_kind_e kind_of(int unsigned b);
    if (b >= B_GPIO_LO || b == B_BUS_INT) return K_LEVEL;
    if (b == B_SUMMARY || b == B_RSVD)    return K_FIXED;
    return K_EVENT;
  endfunction

  function automatic logic [REG_W-1:0] clr_mask();
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (kind_of(i) == K_EVENT);
    return m;
  endfunction

  // summary covers 24:16 and 7:1
  localparam logic [REG_W-1:0] SUM_MASK = 32'h01FF_00FE;
  localparam logic [REG_W-1:0] CLR_MASK = clr_mask();
endpackage

// File: rtl/irq_bit_cell.sv
module irq_bit_cell
  import irq_pkg::*;
#(
  parameter bit_kind_e KIND = K_EVENT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  input  logic clr_i,
  output logic q_o
);
  localparam logic STICKY = (KIND == K_EVENT);

  // set has priority over clear; non-sticky bits follow in_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= in_i | (q_o & ~clr_i & STICKY);
  end

  generate
    if (KIND == K_EVENT) begin : g_evt_chk
      a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_i |=> q_o);
      a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !in_i) |=> !q_o);
      a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_i && !clr_i) |=> $stable(q_o));
    end else if (KIND == K_LEVEL) begin : g_lvl_chk
      a_r5_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (q_o == $past(in_i)));
    end
  endgenerate
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h80,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 'h84,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h88
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  stat_view_i,
  output logic [REG_W-1:0]  clr_o,
  output logic              soft_set_o,
  output logic [REG_W-1:0]  en_o,
  output logic              gie_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic rd_stat, wr_stat, wr_en, wr_ctrl;

  assign rd_stat = rd_i && (addr_i == STAT_ADDR);
  assign wr_stat = wr_i && (addr_i == STAT_ADDR);
  assign wr_en   = wr_i && (addr_i == EN_ADDR);
  assign wr_ctrl = wr_i && (addr_i == CTRL_ADDR);

  assign clr_o      = CLR_MASK & ({REG_W{rd_stat}} | (wr_stat ? wdata_i : '0));
  assign soft_set_o = wr_ctrl & wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      gie_o <= 1'b0;
    end else begin
      if (wr_en)   en_o  <= wdata_i;
      if (wr_ctrl) gie_o <= wdata_i[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      unique case (addr_i)
        STAT_ADDR: rdata_o <= stat_view_i;
        EN_ADDR:   rdata_o <= en_o;
        CTRL_ADDR: rdata_o <= {{(REG_W-2){1'b0}}, gie_o, 1'b0};
        default:   rdata_o <= '0;
      endcase
    end
  end

  a_r3_read_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> (rdata_o == $past(stat_view_i)));
  a_r11_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (en_o == $past(wdata_i)));
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] status_i,
  input  logic [REG_W-1:0] en_i,
  input  logic             gie_i,
  output logic [REG_W-1:0] view_o,
  output logic             irq_o
);
  logic summary;

  assign summary = |(status_i & SUM_MASK);
  assign view_o  = status_i | (REG_W'(summary) << B_SUMMARY);
  assign irq_o   = gie_i & |(view_o & en_i);

  a_r2_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_i);
  a_r7_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !view_o[B_RSVD]);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h80,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 'h84,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h88
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [19:0]       evt_i,
  input  logic              txq_low_i,
  input  logic              rxq_low_i,
  input  logic              timer_zero_i,
  input  logic              stat_wrap_i,
  input  logic              bus_int_i,
  input  logic [3:0]        gpio_i,
  output logic              irq_o
);
  logic [REG_W-1:0] in_vec, clr_vec, status_q, view, en_q;
  logic             soft_set, gie_q;

  always_comb begin
    in_vec                           = '0;
    in_vec[EVT_W-1:0]                = evt_i;
    in_vec[B_BUS_INT]                = bus_int_i;
    in_vec[B_TXQ]                    = txq_low_i;
    in_vec[B_RXQ]                    = rxq_low_i;
    in_vec[B_SOFT]                   = soft_set;
    in_vec[B_TIMER]                  = timer_zero_i;
    in_vec[B_WRAP]                   = stat_wrap_i;
    in_vec[B_GPIO_LO +: GPIO_W]      = gpio_i;
  end

  irq_reg_if #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_reg_if (
    .clk_i, .rst_ni, .rd_i, .wr_i, .addr_i, .wdata_i,
    .stat_view_i (view),
    .clr_o       (clr_vec),
    .soft_set_o  (soft_set),
    .en_o        (en_q),
    .gie_o       (gie_q),
    .rdata_o
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    irq_bit_cell #(.KIND(kind_of(i))) u_cell (
      .clk_i, .rst_ni,
      .in_i  (in_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (status_q[i])
    );
  end

  irq_merge u_merge (
    .clk_i, .rst_ni,
    .status_i (status_q),
    .en_i     (en_q),
    .gie_i    (gie_q),
    .view_o   (view),
    .irq_o
  );

  a_r8_soft_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == CTRL_ADDR && wdata_i[0]) |=> view[B_SOFT]);
  a_r12_unmapped_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != STAT_ADDR && addr_i != EN_ADDR && addr_i != CTRL_ADDR)
      |=> (rdata_o == '0));
endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        is_wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'h84, 32'hA5A5_0F0F, 32'h0},
    '{1'b0, 8'h84, 32'h0,         32'hA5A5_0F0F},  // R11
    '{1'b1, 8'h88, 32'h0000_0002, 32'h0},
    '{1'b0, 8'h88, 32'h0,         32'h0000_0002},  // R11
    '{1'b0, 8'h80, 32'h0,         32'h0},
    '{1'b1, 8'h8C, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 8'h8C, 32'h0,         32'h0},          // R12
    '{1'b0, 8'h84, 32'h0,         32'hA5A5_0F0F},  // R12 write ignored
    '{1'b1, 8'h84, 32'h0,         32'h0},
    '{1'b0, 8'h84, 32'h0,         32'h0},
    '{1'b1, 8'h88, 32'h0,         32'h0},
    '{1'b0, 8'h88, 32'h0,         32'h0}
  };

  logic        clk, rst_n, rd, wr, txq, rxq, tmr, wrap, busint, irq;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [19:0] evt;
  logic [3:0]  gpio;
  int          n_chk = 0, n_bad = 0;

  irq_status_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .txq_low_i(txq),
    .rxq_low_i(rxq), .timer_zero_i(tmr), .stat_wrap_i(wrap),
    .bus_int_i(busint), .gpio_i(gpio), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_evt(input logic [19:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rd = 0; wr = 0; addr = '0; wdata = '0; evt = '0;
    txq = 0; rxq = 0; tmr = 0; wrap = 0; busint = 0; gpio = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    rst_n = 1'b1;
    bus_rd(8'h80, d); chk("R1 status", d, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].is_wr) bus_wr(VECS[i].addr, VECS[i].data);
      else begin
        bus_rd(VECS[i].addr, d);
        chk("R11/R12 table", d, VECS[i].exp);
      end
    end

    // R9 peripheral pulses, R6 summary, R3 read clears
    @(negedge clk); tmr = 1; wrap = 1; rxq = 1; txq = 1;
    @(negedge clk); tmr = 0; wrap = 0; rxq = 0; txq = 0;
    repeat (3) @(negedge clk);
    bus_rd(8'h80, d); chk("R9 sticky events", d, 32'h0B60_0000);
    bus_rd(8'h80, d); chk("R3 cleared after read", d, 32'h0);

    // R6 bits 0 and 8 excluded from summary
    pulse_evt(20'h00101);
    bus_rd(8'h80, d); chk("R6 no summary from 0/8", d, 32'h0000_0101);
    pulse_evt(20'h00020);
    bus_rd(8'h80, d); chk("R6 summary from bit5", d, 32'h0200_0020);

    // R8 soft interrupt
    bus_wr(8'h88, 32'h3);
    bus_rd(8'h88, d); chk("R8 ctrl bit0 reads 0", d, 32'h2);
    bus_rd(8'h80, d); chk("R8 soft bit", d, 32'h0280_0000);

    // R2 / R4 interrupt output and write-one-clear
    bus_wr(8'h84, 32'h8);
    pulse_evt(20'h00008);
    chk("R2 irq on", {31'b0, irq}, 32'h1);
    bus_wr(8'h88, 32'h0);
    chk("R2 irq gated by gie", {31'b0, irq}, 32'h0);
    bus_wr(8'h88, 32'h2);
    chk("R2 irq re-enabled", {31'b0, irq}, 32'h1);
    bus_wr(8'h80, 32'h0);
    chk("R4 write zero keeps", {31'b0, irq}, 32'h1);
    bus_wr(8'h80, 32'h8);
    chk("R4 w1c drops irq", {31'b0, irq}, 32'h0);
    bus_rd(8'h80, d); chk("R4 w1c status", d, 32'h0);

    // R10 collisions
    @(negedge clk); rd = 1; addr = 8'h80; evt = 20'h00200;
    @(negedge clk); rd = 0; evt = '0; d = rdata;
    chk("R10 read before set", d, 32'h0);
    bus_rd(8'h80, d); chk("R10 read-clear collision", d, 32'h0000_0200);
    pulse_evt(20'h00200);
    @(negedge clk); wr = 1; addr = 8'h80; wdata = 32'h200; evt = 20'h00200;
    @(negedge clk); wr = 0; evt = '0;
    bus_rd(8'h80, d); chk("R10 w1c collision", d, 32'h0000_0200);

    // R5 level mirrors, R7 reserved
    @(negedge clk); gpio = 4'b1010; busint = 1;
    @(negedge clk);
    bus_rd(8'h80, d); chk("R5 levels", d, 32'hA210_0000);
    bus_wr(8'h80, 32'hFFFF_FFFF);
    bus_rd(8'h80, d); chk("R5 levels survive clear", d, 32'hA210_0000);
    chk("R7 reserved zero", d & 32'h0400_0000, 32'h0);
    @(negedge clk); gpio = '0; busint = 0;
    @(negedge clk);
    bus_rd(8'h80, d); chk("R5 levels follow source", d, 32'h0);

    // R1 mid-run reset
    bus_wr(8'h84, 32'hFFFF_FFFF);
    pulse_evt(20'h00004);
    chk("R2 irq before reset", {31'b0, irq}, 32'h1);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rst_n = 1;
    bus_rd(8'h84, d); chk("R1 enable after reset", d, 32'h0);
    bus_rd(8'h88, d); chk("R1 ctrl after reset", d, 32'h0);
    bus_rd(8'h80, d); chk("R1 status after reset", d, 32'h0);

    finish_run();
  end
endmodule